// File: doc/BRIEF.md
# Memory-Mapped Up/Down Counter Peripheral

This block is a slave on a simple valid/ready memory bus. It holds a free-running 32-bit counter whose direction comes from a two-bit mode register. Software sets the mode with a bus write and samples the count with a bus read. On every clock the counter steps up by one, steps down by one, or holds, according to the stored mode. It wraps silently at both ends of its range.

The bus carries address, write data, byte strobes and read data. An access with all strobes low is a read, and any strobe set makes it a write. The master raises `bus_valid` and holds address, data and strobes stable until `bus_ready` is seen high. For a decoded address the slave answers with exactly one cycle of latency. `bus_ready` is a single-cycle pulse, and `bus_rdata` is valid only in that cycle. No back-pressure is possible on the return path, so the master must take the read data in the ready cycle. The master drops `bus_valid` in the cycle after ready, or presents its next request there. Addresses outside the two decoded words are never acknowledged, which leaves them free for another slave on a shared bus.

Top module: `updown_ctr_periph`

## Requirements
- R1: A synchronous active-low reset clears the count to 0, the mode to idle (2'b00) and `bus_ready` to 0.
- R2: Mode codes 2'b00 and 2'b11 keep the count unchanged from one clock to the next.
- R3: Mode 2'b01 adds one to the count on every clock, and 0xFFFFFFFF is followed by 0x00000000.
- R4: Mode 2'b10 subtracts one from the count on every clock, and 0x00000000 is followed by 0xFFFFFFFF.
- R5: A read (all four strobes low) at address 0x40000000 returns the count as it stood in the cycle before `bus_ready` rises.
- R6: A write at address 0x40000004 with strobe bit 0 set stores write-data bits [1:0] as the new mode, and ignores bits [31:2]. The new mode governs the count from the clock after the one that raises `bus_ready`.
- R7: A write at 0x40000004 with strobe bit 0 clear is acknowledged but leaves the mode unchanged.
- R8: A write at 0x40000000 is acknowledged and has no effect on the count or the mode.
- R9: A read at 0x40000004 returns 0.
- R10: For a decoded address `bus_ready` rises one cycle after `bus_valid` is first seen and stays high for exactly one cycle. `bus_rdata` is 0 whenever `bus_ready` is low.
- R11: An access to any other address never raises `bus_ready` and changes neither the mode nor the count's direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Request valid, held until ready |
| bus_addr | input | 32 | Byte address of the request |
| bus_wdata | input | 32 | Write data |
| bus_wstrb | input | 4 | Byte strobes; all zero means read |
| bus_ready | output | 1 | One-cycle acknowledge |
| bus_rdata | output | 32 | Read data, valid while ready is high |

## Verification
Every mode code is written with idle gaps of zero to five cycles before the count is read twice. The difference between the two reads separates holding, climbing by two and falling by two, and shows that the upper write-data bits have no effect. A fixed sequence that starts from reset drives the count down through zero and back up across the top of the range, which pins both wrap directions and the exact cycle a new mode takes hold. Writes with only upper strobes set, writes to the read-only count word and held accesses to unmapped words are each followed by reads. These reads show that the mode and count are untouched, and the held accesses confirm that no acknowledge appears.

// File: rtl/ctr_periph_pkg.sv
package ctr_periph_pkg;

  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_IDLE = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_HOLD = 2'b11
  } ctr_mode_e;

  typedef enum logic [1:0] {
    SEL_NONE  = 2'd0,
    SEL_COUNT = 2'd1,
    SEL_MODE  = 2'd2
  } reg_sel_e;

endpackage

// File: rtl/ctr_bus_decode.sv
module ctr_bus_decode
  import ctr_periph_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                STRB_W     = 4,
  parameter logic [ADDR_W-1:0] COUNT_ADDR = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 32'h4000_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  logic [ADDR_W-1:0] addr,
  input  logic [STRB_W-1:0] wstrb,
  output reg_sel_e          sel,
  output logic              accept,
  output logic              is_write,
  output logic              ready
);

  logic ready_q;

  always_comb begin
    sel = SEL_NONE;
    if (addr == COUNT_ADDR)     sel = SEL_COUNT;
    else if (addr == MODE_ADDR) sel = SEL_MODE;
  end

  // a request is taken once; the following cycle carries the acknowledge
  assign accept   = valid && (sel != SEL_NONE) && !ready_q;
  assign is_write = |wstrb;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= accept;
  end

  assign ready = ready_q;

endmodule

// File: rtl/ctr_mode_reg.sv
module ctr_mode_reg
  import ctr_periph_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wdata_lo,
  output ctr_mode_e         mode
);

  ctr_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     mode_q <= MODE_IDLE;
    else if (wr_en) mode_q <= ctr_mode_e'(wdata_lo);
  end

  assign mode = mode_q;

endmodule

// File: rtl/ctr_count_core.sv
module ctr_count_core
  import ctr_periph_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctr_mode_e        mode,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // modular arithmetic gives both wrap directions without extra compare
  always_comb begin
    unique case (mode)
      MODE_UP:   cnt_d = cnt_q + CNT_W'(1);
      MODE_DOWN: cnt_d = cnt_q - CNT_W'(1);
      default:   cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/ctr_rdata_mux.sv
module ctr_rdata_mux
  import ctr_periph_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              is_write,
  input  reg_sel_e          sel,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] cnt_ext;
  logic [DATA_W-1:0] rdata_q;

  generate
    if (CNT_W < DATA_W) begin : g_pad
      assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, count};
    end else begin : g_fit
      assign cnt_ext = count[DATA_W-1:0];
    end
  endgenerate

  // returns zero outside the acknowledge cycle and for the mode word
  always_ff @(posedge clk) begin
    if (!rst_n)                                         rdata_q <= '0;
    else if (accept && !is_write && sel == SEL_COUNT)   rdata_q <= cnt_ext;
    else                                                rdata_q <= '0;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/updown_ctr_periph.sv
module updown_ctr_periph
  import ctr_periph_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 32,
  parameter logic [ADDR_W-1:0] COUNT_ADDR = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 32'h4000_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W/8-1:0] bus_wstrb,
  output logic              bus_ready,
  output logic [DATA_W-1:0] bus_rdata
);

  localparam int STRB_W = DATA_W / 8;

  reg_sel_e         sel;
  logic             accept;
  logic             is_write;
  logic             mode_wr;
  ctr_mode_e        mode;
  logic [CNT_W-1:0] count;
  logic             unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[DATA_W-1:MODE_W];

  ctr_bus_decode #(
    .ADDR_W(ADDR_W), .STRB_W(STRB_W),
    .COUNT_ADDR(COUNT_ADDR), .MODE_ADDR(MODE_ADDR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .valid(bus_valid), .addr(bus_addr),
    .wstrb(bus_wstrb), .sel(sel), .accept(accept),
    .is_write(is_write), .ready(bus_ready)
  );

  assign mode_wr = accept && is_write && (sel == SEL_MODE) && bus_wstrb[0];

  ctr_mode_reg u_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(mode_wr),
    .wdata_lo(bus_wdata[MODE_W-1:0]), .mode(mode)
  );

  ctr_count_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .mode(mode), .count(count)
  );

  ctr_rdata_mux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rmux (
    .clk(clk), .rst_n(rst_n), .accept(accept), .is_write(is_write),
    .sel(sel), .count(count), .rdata(bus_rdata)
  );

endmodule

// File: rtl/ctr_periph_chk.sv
module ctr_periph_chk #(
  parameter int                ADDR_W     = 32,
  parameter int                DATA_W     = 32,
  parameter int                CNT_W      = 32,
  parameter logic [ADDR_W-1:0] COUNT_ADDR = 32'h4000_0000,
  parameter logic [ADDR_W-1:0] MODE_ADDR  = 32'h4000_0004
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        wdata_lo,
  input logic [DATA_W/8-1:0] bus_wstrb,
  input logic              bus_ready,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [CNT_W-1:0]  count,
  input logic [1:0]        mode
);

  logic hit;
  logic mode_wr_req;
  assign hit         = (bus_addr == COUNT_ADDR) || (bus_addr == MODE_ADDR);
  assign mode_wr_req = bus_valid && !bus_ready && (bus_addr == MODE_ADDR) && bus_wstrb[0];

  p_reset_state_r1: assert property (@(posedge clk)
    !rst_n |=> (count == '0) && (mode == 2'b00) && !bus_ready);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 || mode == 2'b11) |=> $stable(count));

  p_count_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01) |=> count == $past(count) + CNT_W'(1));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b10) |=> count == $past(count) - CNT_W'(1));

  p_read_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && $past(bus_addr == COUNT_ADDR && bus_wstrb == '0))
      |-> bus_rdata == DATA_W'($past(count)));

  p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr_req |=> mode == $past(wdata_lo));

  p_mode_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_wr_req |=> $stable(mode));

  p_mode_read_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ready && $past(bus_addr == MODE_ADDR && bus_wstrb == '0)) |-> bus_rdata == '0);

  p_ack_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && hit && !bus_ready) |=> bus_ready);

  p_ack_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);

  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> bus_rdata == '0);

  p_no_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !hit) |=> !bus_ready);

endmodule

bind updown_ctr_periph ctr_periph_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
  .COUNT_ADDR(COUNT_ADDR), .MODE_ADDR(MODE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
  .wdata_lo(bus_wdata[1:0]), .bus_wstrb(bus_wstrb), .bus_ready(bus_ready),
  .bus_rdata(bus_rdata), .count(count), .mode(mode)
);

// File: tb/tb_updown_ctr_periph.sv
`timescale 1ns/1ps
module tb_updown_ctr_periph;

  localparam logic [31:0] A_CNT  = 32'h4000_0000;
  localparam logic [31:0] A_MODE = 32'h4000_0004;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_wstrb = '0;
  logic        bus_ready;
  logic [31:0] bus_rdata;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  updown_ctr_periph dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wstrb(bus_wstrb),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata)
  );

  // reference built from the requirements
  logic [31:0] m_cnt, m_snap;
  logic [1:0]  m_mode;
  logic        m_rdy;
  wire         m_hit = (bus_addr == A_CNT) || (bus_addr == A_MODE);
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_mode <= '0; m_rdy <= 1'b0; m_snap <= '0;
    end else begin
      if (m_mode == 2'b01)      m_cnt <= m_cnt + 32'd1;
      else if (m_mode == 2'b10) m_cnt <= m_cnt - 32'd1;
      m_rdy <= bus_valid && m_hit && !m_rdy;
      if (bus_valid && m_hit && !m_rdy) begin
        if (bus_addr == A_MODE && bus_wstrb[0]) m_mode <= bus_wdata[1:0];
        if (bus_wstrb == 4'b0) m_snap <= (bus_addr == A_CNT) ? m_cnt : 32'd0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [31:0] a, input string req, output logic [31:0] got);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_wstrb = 4'b0; bus_wdata = '0;
    check(bus_ready == 1'b0, "R10 no early ready", {31'b0, bus_ready}, 32'd0);
    @(negedge clk);
    check(bus_ready == 1'b1, "R10 ready after one cycle", {31'b0, bus_ready}, 32'd1);
    got = bus_rdata;
    check(got === m_snap, req, got, m_snap);
    bus_valid = 1'b0;
  endtask

  task automatic do_write(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s, input string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    @(negedge clk);
    check(bus_ready == 1'b1, req, {31'b0, bus_ready}, 32'd1);
    check(bus_rdata == '0, "R10 write returns zero", bus_rdata, 32'd0);
    bus_valid = 1'b0; bus_wstrb = 4'b0;
  endtask

  task automatic stray(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
    @(negedge clk);
    bus_valid = 1'b1; bus_addr = a; bus_wdata = d; bus_wstrb = s;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(bus_ready == 1'b0, "R11 unmapped not acked", {31'b0, bus_ready}, 32'd0);
    end
    bus_valid = 1'b0; bus_wstrb = 4'b0;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [31:0] a, b, r;
    repeat (4) @(negedge clk);
    check(bus_ready == 1'b0 && bus_rdata == '0, "R1 reset outputs", bus_rdata, 32'd0);
    rst_n = 1'b1;
    do_read(A_CNT, "R1 count zero after reset", r);
    check(r == 32'd0, "R1 idle count", r, 32'd0);

    // wrap sequence from reset
    do_write(A_MODE, 32'd2, 4'hF, "R6 mode write acked");
    do_read(A_CNT, "R4 down", r);
    check(r == 32'hFFFF_FFFF, "R4 wrap below zero", r, 32'hFFFF_FFFF);
    do_write(A_MODE, 32'hABCD_0001, 4'hF, "R6 mode write acked");
    do_read(A_CNT, "R6 switch timing", r);
    check(r == 32'hFFFF_FFFD, "R6 new mode from next clock", r, 32'hFFFF_FFFD);
    do_read(A_CNT, "R3 up", r);
    check(r == 32'hFFFF_FFFF, "R3 up near top", r, 32'hFFFF_FFFF);
    do_read(A_CNT, "R3 up", r);
    check(r == 32'h0000_0001, "R3 wrap above top", r, 32'h0000_0001);

    // sweep over every mode code and idle gap
    for (int m = 0; m < 4; m++) begin
      for (int g = 0; g < 6; g++) begin
        do_write(A_MODE, {30'h2AAA_AAAA ^ 30'(g), 2'(m)}, 4'h1, "R6 mode write acked");
        repeat (g) @(negedge clk);
        do_read(A_CNT, "R5 read value", a);
        do_read(A_CNT, "R5 read value", b);
        case (m)
          1:       check(b - a == 32'd2, "R3 step up", b - a, 32'd2);
          2:       check(a - b == 32'd2, "R4 step down", a - b, 32'd2);
          default: check(b == a, "R2 hold", b, a);
        endcase
        do_read(A_MODE, "R9 mode reads zero", r);
        check(r == 32'd0, "R9 mode reads zero", r, 32'd0);
      end
    end

    // R7: mode write without byte 0 strobe
    do_write(A_MODE, 32'd0, 4'h1, "R6 mode write acked");
    do_write(A_MODE, 32'hFFFF_FF01, 4'b1110, "R7 write acked");
    do_read(A_CNT, "R7 mode unchanged", a);
    do_read(A_CNT, "R7 mode unchanged", b);
    check(b == a, "R7 count still idle", b, a);

    // R8: write to the count word
    do_write(A_CNT, 32'h1234_5678, 4'hF, "R8 write acked");
    do_read(A_CNT, "R8 count unchanged", b);
    check(b == a, "R8 count unchanged", b, a);

    // R11: unmapped addresses
    stray(32'h4000_0008, 32'd1, 4'hF);
    stray(32'h0000_0000, 32'd0, 4'h0);
    stray(32'h4000_0005, 32'd2, 4'h1);
    do_read(A_CNT, "R11 no side effect", b);
    check(b == a, "R11 mode still idle", b, a);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule